// File: doc/BRIEF.md
# Sleep and Wake Power Sequencer

This block takes a system into a low-power sleep state and brings it out again. A sleep command makes it raise a request towards a clock-control agent. Once that agent acknowledges, the block drives five power-control outputs. Each output changes state after its own programmed number of ticks of a slow timebase. The five outputs are an input-isolation control, two generic sleep controls, an output-isolation control and an active-low clock-off signal.

A wake event releases the controls in reverse order. The active-low clock-off signal is released on the wake event itself. Every other enabled control is released after the largest enabled delay minus its own delay. Each control has an enable bit and a delay, written through a narrow register port while the block is idle. Delay settings that break the ordering rules between controls raise a configuration error, and sleep entry is refused while that error stands.

Top module: `sleep_seq_top`

## Requirements
- R1: A sleep command in idle, with no configuration error and no configuration write in that cycle or the cycle before, raises the sleep request on the next clock edge, and status reads entering (1).
- R2: No control asserts before the acknowledge. A control with delay 0 asserts on the edge that samples the acknowledge. After that, each enabled control asserts on the edge that counts its delay-th tick. Control indices are: 0 input isolation, 1 generic A, 2 generic B, 3 output isolation, 4 clock-off.
- R3: A control whose enable is clear never asserts. Once every enabled control has asserted, status reads asleep (2).
- R4: The configuration error is set one edge after the settings break a rule. The rules are: an enabled generic control's delay must be strictly greater than the enabled input-isolation delay and strictly less than the enabled output-isolation delay; and when clock-off is enabled, each enabled generic and output-isolation delay must be strictly less than the clock-off delay. While the error is set, a sleep command is ignored.
- R5: The clock-off output is active low and returns high on the edge that samples the accepted wake event, whatever its delay.
- R6: A wake event is accepted only in the asleep state. During request or entry it has no effect, so with clock-off enabled, wake is never taken before clock-off has asserted.
- R7: Let M be the largest enabled delay. After an accepted wake, every other enabled control releases on the edge that counts tick number M minus its own delay, where zero means the wake edge. Status returns to idle on the edge that counts tick M.
- R8: The sleep request drops on the wake edge. Status reads waking (3) until the release completes.
- R9: Configuration writes are ignored outside the idle state.
- R10: After reset, the request and all controls are deasserted (clock-off output high), status is idle (0) and the configuration error is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase tick, one cycle wide |
| sleep_go | input | 1 | Sleep command |
| wake_evt | input | 1 | Wake event |
| slp_ack | input | 1 | Sleep acknowledge from the clock agent |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Control index to write (0..4) |
| cfg_en | input | 1 | Enable bit to write |
| cfg_dly | input | DLY_W | Delay in ticks to write |
| slp_req | output | 1 | Sleep request to the clock agent |
| iso_in | output | 1 | Input-isolation control |
| gen_a | output | 1 | Generic sleep control A |
| gen_b | output | 1 | Generic sleep control B |
| iso_out | output | 1 | Output-isolation control |
| clk_off_n | output | 1 | Clock-off control, active low |
| cfg_err | output | 1 | Delay ordering rule broken |
| status | output | 2 | 0 idle, 1 entering, 2 asleep, 3 waking |

## Verification
The bench builds the sequencer with DLY_W set to 3, so every delay lies between 0 and 7 and a full entry and wake cycle takes at most a few dozen clocks. That makes it practical to sweep all 32 enable masks against seventeen delay patterns. The patterns include one known-good ordering and a spread that lands on both sides of every ordering rule, so both refused and accepted entries are covered, including the zero-delay and equal-delay boundaries. The expected tick at which each control asserts and releases is computed from the enable mask and the delays alone.

// File: rtl/sleep_seq_pkg.sv
`timescale 1ns/1ps
package sleep_seq_pkg;
  localparam int NCTL       = 5;
  localparam int CI_ISO_IN  = 0;
  localparam int CI_GEN_A   = 1;
  localparam int CI_GEN_B   = 2;
  localparam int CI_ISO_OUT = 3;
  localparam int CI_CLK_OFF = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ENTER,
    ST_ASLEEP,
    ST_WAKE
  } seq_state_e;

  typedef enum logic [1:0] {
    SS_IDLE     = 2'd0,
    SS_ENTERING = 2'd1,
    SS_ASLEEP   = 2'd2,
    SS_WAKING   = 2'd3
  } seq_status_e;
endpackage

// File: rtl/sleep_seq_cfg.sv
`timescale 1ns/1ps
module sleep_seq_cfg
  import sleep_seq_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_ok,
  input  logic [2:0]                 sel,
  input  logic                       en_in,
  input  logic [DLY_W-1:0]           dly_in,
  output logic [NCTL-1:0]            en_q,
  output logic [NCTL-1:0][DLY_W-1:0] dly_q,
  output logic [DLY_W-1:0]           dmax,
  output logic                       cfg_err,
  output logic                       wr_pend
);
  logic err_c;

  // settings storage, written only when the sequencer allows it
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      dly_q   <= '0;
      wr_pend <= 1'b0;
    end else begin
      wr_pend <= wr_ok;
      if (wr_ok && (int'(sel) < NCTL)) begin
        en_q[sel]  <= en_in;
        dly_q[sel] <= dly_in;
      end
    end
  end

  // ordering rule check between the enabled controls
  always_comb begin
    err_c = 1'b0;
    for (int g = CI_GEN_A; g <= CI_GEN_B; g++) begin
      if (en_q[g] && en_q[CI_ISO_IN] && (dly_q[CI_ISO_IN] >= dly_q[g]))
        err_c = 1'b1;
      if (en_q[g] && en_q[CI_ISO_OUT] && (dly_q[g] >= dly_q[CI_ISO_OUT]))
        err_c = 1'b1;
    end
    if (en_q[CI_CLK_OFF]) begin
      for (int x = CI_GEN_A; x <= CI_ISO_OUT; x++) begin
        if (en_q[x] && (dly_q[x] >= dly_q[CI_CLK_OFF]))
          err_c = 1'b1;
      end
    end
  end

  // longest enabled delay: end of entry and length of wake
  always_comb begin
    dmax = '0;
    for (int k = 0; k < NCTL; k++) begin
      if (en_q[k] && (dly_q[k] > dmax))
        dmax = dly_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= err_c;
  end
endmodule

// File: rtl/sleep_seq_timer.sv
`timescale 1ns/1ps
module sleep_seq_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  output logic [DLY_W-1:0] elapsed
);
  localparam logic [DLY_W-1:0] CNT_MAX = '1;

  logic [DLY_W-1:0] cnt_q;

  // elapsed ticks including this cycle's tick; zero on a phase start
  always_comb begin
    if (restart)
      elapsed = '0;
    else if (tick && (cnt_q != CNT_MAX))
      elapsed = cnt_q + 1'b1;
    else
      elapsed = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= elapsed;
  end
endmodule

// File: rtl/sleep_seq_lane.sv
`timescale 1ns/1ps
module sleep_seq_lane #(
  parameter int DLY_W          = 8,
  parameter bit FORCE_WAKE_REL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DLY_W-1:0] dly,
  input  logic [DLY_W-1:0] dmax,
  input  logic [DLY_W-1:0] elapsed,
  input  logic             asrt_win,
  input  logic             rel_win,
  input  logic             wake_edge,
  output logic             on
);
  logic [DLY_W-1:0] rel_at;
  logic             rel_now;

  // mirrored release point gives the reverse order on wake
  assign rel_at  = (dmax >= dly) ? (dmax - dly) : '0;
  assign rel_now = rel_win && ((elapsed >= rel_at) || (FORCE_WAKE_REL && wake_edge));

  always_ff @(posedge clk) begin
    if (rst)
      on <= 1'b0;
    else if (rel_now)
      on <= 1'b0;
    else if (asrt_win && en && (elapsed >= dly))
      on <= 1'b1;
  end
endmodule

// File: rtl/sleep_seq_fsm.sv
`timescale 1ns/1ps
module sleep_seq_fsm
  import sleep_seq_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_go,
  input  logic             wake_evt,
  input  logic             slp_ack,
  input  logic             cfg_we,
  input  logic             wr_pend,
  input  logic             cfg_err,
  input  logic [DLY_W-1:0] elapsed,
  input  logic [DLY_W-1:0] dmax,
  output logic             restart,
  output logic             asrt_win,
  output logic             rel_win,
  output logic             wake_edge,
  output logic             idle,
  output logic             slp_req,
  output logic [1:0]       status
);
  seq_state_e st_q, st_nx;
  logic       ack_edge;

  assign ack_edge  = (st_q == ST_REQ) && slp_ack;
  assign wake_edge = (st_q == ST_ASLEEP) && wake_evt;
  assign restart   = ack_edge || wake_edge;
  assign asrt_win  = ack_edge || (st_q == ST_ENTER);
  assign rel_win   = wake_edge || (st_q == ST_WAKE);
  assign idle      = (st_q == ST_IDLE);

  always_comb begin
    st_nx = st_q;
    case (st_q)
      ST_IDLE:   if (sleep_go && !cfg_we && !wr_pend && !cfg_err) st_nx = ST_REQ;
      ST_REQ:    if (slp_ack) st_nx = ST_ENTER;
      ST_ENTER:  if (elapsed >= dmax) st_nx = ST_ASLEEP;
      ST_ASLEEP: if (wake_evt) st_nx = ST_WAKE;
      ST_WAKE:   if (elapsed >= dmax) st_nx = ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      slp_req <= 1'b0;
      status  <= SS_IDLE;
    end else begin
      st_q    <= st_nx;
      slp_req <= (st_nx == ST_REQ) || (st_nx == ST_ENTER) || (st_nx == ST_ASLEEP);
      case (st_nx)
        ST_REQ, ST_ENTER: status <= SS_ENTERING;
        ST_ASLEEP:        status <= SS_ASLEEP;
        ST_WAKE:          status <= SS_WAKING;
        default:          status <= SS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sleep_seq_top.sv
`timescale 1ns/1ps
module sleep_seq_top
  import sleep_seq_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             sleep_go,
  input  logic             wake_evt,
  input  logic             slp_ack,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic             cfg_en,
  input  logic [DLY_W-1:0] cfg_dly,
  output logic             slp_req,
  output logic             iso_in,
  output logic             gen_a,
  output logic             gen_b,
  output logic             iso_out,
  output logic             clk_off_n,
  output logic             cfg_err,
  output logic [1:0]       status
);
  logic [NCTL-1:0]            en_q;
  logic [NCTL-1:0][DLY_W-1:0] dly_q;
  logic [DLY_W-1:0]           dmax;
  logic [DLY_W-1:0]           elapsed;
  logic                       wr_pend, restart, asrt_win, rel_win, wake_edge, idle;
  logic [NCTL-1:0]            ctl_on;

  sleep_seq_cfg #(.DLY_W(DLY_W)) i_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_ok   (cfg_we && idle),
    .sel     (cfg_sel),
    .en_in   (cfg_en),
    .dly_in  (cfg_dly),
    .en_q    (en_q),
    .dly_q   (dly_q),
    .dmax    (dmax),
    .cfg_err (cfg_err),
    .wr_pend (wr_pend)
  );

  sleep_seq_timer #(.DLY_W(DLY_W)) i_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .tick    (tick),
    .elapsed (elapsed)
  );

  sleep_seq_fsm #(.DLY_W(DLY_W)) i_fsm (
    .clk       (clk),
    .rst       (rst),
    .sleep_go  (sleep_go),
    .wake_evt  (wake_evt),
    .slp_ack   (slp_ack),
    .cfg_we    (cfg_we),
    .wr_pend   (wr_pend),
    .cfg_err   (cfg_err),
    .elapsed   (elapsed),
    .dmax      (dmax),
    .restart   (restart),
    .asrt_win  (asrt_win),
    .rel_win   (rel_win),
    .wake_edge (wake_edge),
    .idle      (idle),
    .slp_req   (slp_req),
    .status    (status)
  );

  for (genvar g = 0; g < NCTL; g++) begin : g_lane
    sleep_seq_lane #(
      .DLY_W          (DLY_W),
      .FORCE_WAKE_REL (g == CI_CLK_OFF)
    ) i_lane (
      .clk       (clk),
      .rst       (rst),
      .en        (en_q[g]),
      .dly       (dly_q[g]),
      .dmax      (dmax),
      .elapsed   (elapsed),
      .asrt_win  (asrt_win),
      .rel_win   (rel_win),
      .wake_edge (wake_edge),
      .on        (ctl_on[g])
    );
  end

  assign iso_in    = ctl_on[CI_ISO_IN];
  assign gen_a     = ctl_on[CI_GEN_A];
  assign gen_b     = ctl_on[CI_GEN_B];
  assign iso_out   = ctl_on[CI_ISO_OUT];
  assign clk_off_n = ~ctl_on[CI_CLK_OFF];
endmodule

// File: rtl/sleep_seq_chk.sv
`timescale 1ns/1ps
module sleep_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       sleep_go,
  input logic       slp_req,
  input logic       iso_in,
  input logic       gen_a,
  input logic       gen_b,
  input logic       iso_out,
  input logic       clk_off_n,
  input logic       cfg_err,
  input logic [1:0] status
);
  logic any_ctl;
  assign any_ctl = iso_in | gen_a | gen_b | iso_out | ~clk_off_n;

  p_req_after_go_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(slp_req) |-> $past(sleep_go));

  p_ctl_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(any_ctl) |-> slp_req);

  p_err_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && status == 2'd0 && !slp_req) |=> !slp_req);

  p_wake_frees_clk_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(slp_req) |-> clk_off_n);

  p_wake_from_asleep_r6: assert property (@(posedge clk) disable iff (rst)
    (status == 2'd3 && $past(status) != 2'd3) |-> $past(status) == 2'd2);

  p_asleep_holds_req_r8: assert property (@(posedge clk) disable iff (rst)
    (status == 2'd2) |-> slp_req);
endmodule

bind sleep_seq_top sleep_seq_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .sleep_go  (sleep_go),
  .slp_req   (slp_req),
  .iso_in    (iso_in),
  .gen_a     (gen_a),
  .gen_b     (gen_b),
  .iso_out   (iso_out),
  .clk_off_n (clk_off_n),
  .cfg_err   (cfg_err),
  .status    (status)
);

// File: tb/test_sleep_seq_top.sv
`timescale 1ns/1ps
module test_sleep_seq_top;
  localparam int DW = 3;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, sleep_go = 1'b0, wake_evt = 1'b0;
  logic slp_ack = 1'b0, cfg_we = 1'b0, cfg_en = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [DW-1:0] cfg_dly = '0;
  logic slp_req, iso_in, gen_a, gen_b, iso_out, clk_off_n, cfg_err;
  logic [1:0] status;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  bit [4:0] m_en = '0;
  int m_d [5];

  sleep_seq_top #(.DLY_W(DW)) i_sleep_seq_top (
    .clk(clk), .rst(rst), .tick(tick), .sleep_go(sleep_go), .wake_evt(wake_evt),
    .slp_ack(slp_ack), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en),
    .cfg_dly(cfg_dly), .slp_req(slp_req), .iso_in(iso_in), .gen_a(gen_a),
    .gen_b(gen_b), .iso_out(iso_out), .clk_off_n(clk_off_n), .cfg_err(cfg_err),
    .status(status)
  );

  always #2 clk = ~clk;

  function automatic logic [4:0] ctl();
    return {~clk_off_n, iso_out, gen_b, gen_a, iso_in};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input int sel, input bit en, input int d, input bit upd);
    cfg_we = 1'b1; cfg_sel = sel[2:0]; cfg_en = en; cfg_dly = d[DW-1:0];
    step();
    cfg_we = 1'b0;
    if (upd) begin m_en[sel] = en; m_d[sel] = d; end
  endtask

  function automatic bit exp_err();
    bit e = 1'b0;
    for (int g = 1; g <= 2; g++) begin
      if (m_en[g] && m_en[0] && !(m_d[0] < m_d[g])) e = 1'b1;
      if (m_en[g] && m_en[3] && !(m_d[g] < m_d[3])) e = 1'b1;
    end
    if (m_en[4])
      for (int x = 1; x <= 3; x++)
        if (m_en[x] && !(m_d[x] < m_d[4])) e = 1'b1;
    return e;
  endfunction

  function automatic int dmax_f();
    int m = 0;
    for (int k = 0; k < 5; k++) if (m_en[k] && m_d[k] > m) m = m_d[k];
    return m;
  endfunction

  task automatic run_seq();
    bit e;
    int dm;
    logic [4:0] ev;
    e  = exp_err();
    dm = dmax_f();
    step(); step();
    chk(cfg_err == e, "R4 config error flag", cfg_err, e);
    sleep_go = 1'b1; step(); sleep_go = 1'b0;
    if (e) begin
      chk(slp_req == 1'b0 && status == 2'd0, "R4 entry refused", {status, slp_req}, 0);
      return;
    end
    chk(slp_req == 1'b1 && status == 2'd1, "R1 request raised", {status, slp_req}, 3);
    // tick and wake while waiting for the acknowledge
    tick = 1'b1; wake_evt = 1'b1; step(); tick = 1'b0; wake_evt = 1'b0;
    chk(ctl() == 5'd0 && status == 2'd1, "R2 R6 nothing before ack", {ctl(), status}, 1);
    slp_ack = 1'b1; step(); slp_ack = 1'b0;
    for (int n = 0; n <= dm; n++) begin
      if (n > 0) begin
        tick = 1'b1; if (n == 1) wake_evt = 1'b1;
        step();
        tick = 1'b0; wake_evt = 1'b0;
      end
      for (int k = 0; k < 5; k++) ev[k] = m_en[k] && (m_d[k] <= n);
      chk(ctl() == ev, "R2 R3 assert timing", ctl(), ev);
      if (n == 1)
        chk(slp_req && status == ((dm == 1) ? 2'd2 : 2'd1), "R6 wake ignored while entering",
            status, (dm == 1) ? 2 : 1);
    end
    step();
    chk(status == 2'd2 && slp_req, "R3 R8 asleep", {status, slp_req}, 5);
    chk(ctl() == m_en, "R3 asleep controls", ctl(), m_en);
    wake_evt = 1'b1; step(); wake_evt = 1'b0;
    for (int n = 0; n <= dm; n++) begin
      if (n > 0) begin tick = 1'b1; step(); tick = 1'b0; end
      for (int k = 0; k < 5; k++) ev[k] = m_en[k] && (k != 4) && ((dm - m_d[k]) > n);
      chk(ctl() == ev, "R7 release timing", ctl(), ev);
      if (n == 0) begin
        chk(slp_req == 1'b0 && status == 2'd3, "R8 waking", {status, slp_req}, 6);
        chk(clk_off_n == 1'b1, "R5 clock-off freed on wake", clk_off_n, 1);
      end
    end
    step();
    chk(status == 2'd0 && ctl() == 5'd0, "R7 back to idle", {ctl(), status}, 0);
  endtask

  task automatic set_cfg(input int m, input int p);
    int d;
    for (int k = 0; k < 5; k++) begin
      if (p == 16) d = (k == 4) ? 6 : k + 1;
      else         d = (p * (2 * k + 1) + k) & 7;
      wr(k, m[k], d, 1'b1);
    end
  endtask

  initial begin
    for (int k = 0; k < 5; k++) m_d[k] = 0;
    repeat (3) step();
    rst = 1'b0;
    step();
    chk(slp_req == 1'b0 && status == 2'd0 && cfg_err == 1'b0, "R10 reset state",
        {cfg_err, status, slp_req}, 0);
    chk(ctl() == 5'd0 && clk_off_n == 1'b1, "R10 controls idle", ctl(), 0);

    for (int m = 0; m < 32; m++)
      for (int p = 0; p <= 16; p++) begin
        set_cfg(m, p);
        run_seq();
      end

    // R9: a write while asleep must not change the settings
    set_cfg(31, 16);
    step(); step();
    sleep_go = 1'b1; step(); sleep_go = 1'b0;
    slp_ack = 1'b1; step(); slp_ack = 1'b0;
    for (int n = 0; n < 6; n++) begin tick = 1'b1; step(); tick = 1'b0; end
    step();
    chk(status == 2'd2, "R9 asleep before write", status, 2);
    wr(3, 1'b1, 0, 1'b0);
    wake_evt = 1'b1; step(); wake_evt = 1'b0;
    for (int n = 0; n < 6; n++) begin tick = 1'b1; step(); tick = 1'b0; end
    step(); step(); step();
    chk(status == 2'd0 && cfg_err == 1'b0, "R9 write ignored when not idle", cfg_err, 0);
    run_seq();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule